// File: doc/BRIEF.md
# Float and Integer Conversion Unit

This unit converts values between IEEE 754 single precision and 32-bit two's-complement integers. A caller presents a 32-bit operand and a 2-bit operation code together with a one-cycle `start` strobe. After a fixed latency that depends on the operation, the unit raises `done` for exactly one cycle. The converted value appears on `result` in that same cycle and stays there until the next operation completes.

There are two float-to-integer operations, and they differ only in how they round. One rounds toward zero. The other rounds to the nearest integer and sends an exact half away from zero. Both clamp values outside the integer range to the integer limits. Both treat subnormal inputs as zero. Both map every NaN to the most negative integer, so the result is always defined. Each of these operations finishes one cycle after `start`.

The integer-to-float operation has two internal stages. The first takes the sign and magnitude. The second normalises the magnitude with a leading-zero count. The output register then rounds the significand and packs the result. This operation finishes three cycles after `start`.

Top module: `fcvt_unit`

## Requirements
- R1: Operation code 0 converts a float to an integer by rounding toward zero. For example, 4.8 gives 4 and -1.5 gives -1.
- R2: Operation code 1 converts a float to an integer by rounding to nearest, with an exact half moving away from zero. For example, 4.8 gives 5, -1.5 gives -2 and 2.5 gives 3.
- R3: Under codes 0 and 1, +infinity and any float of 2^31 or more give 0x7FFFFFFF.
- R4: Under codes 0 and 1, -infinity and any float below -2^31 give 0x80000000. The value -2^31 itself converts exactly to 0x80000000.
- R5: Under codes 0 and 1, a NaN (biased exponent 0xFF with a non-zero fraction) gives 0x80000000.
- R6: Under codes 0 and 1, a float with biased exponent 0 (a zero or a subnormal, of either sign) gives 0.
- R7: Operation code 2 converts a signed integer to a float. An integer with at most 24 significant bits converts exactly. A wider integer rounds to nearest, with an exact half moving away from zero. Zero gives +0, -2^31 gives 0xCF000000, and the output is never subnormal.
- R8: For codes 0, 1 and 3, `done` is high in the cycle after the clock edge that captured `start`. For code 2, `done` is high three cycles after that edge.
- R9: Operation code 3 returns 0.
- R10: Each accepted `start` produces exactly one single-cycle `done` pulse. `done` stays low at every other time, including the cycles in which an integer-to-float operation is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation; sampled on the rising edge |
| op | input | 2 | Operation code: 0 truncate, 1 round, 2 int-to-float, 3 zero |
| operand | input | 32 | Float bit pattern or two's-complement integer |
| result | output | 32 | Converted value, valid when `done` is high |
| done | output | 1 | One-cycle completion strobe |

## Verification
For the float-to-integer operations, the bench sweeps every biased exponent under both signs with a set of fraction patterns. This covers the transition into saturation at 2^31, the exact -2^31 point, infinities, NaNs and subnormals. A design that shifted by one position too many or too few would miscompare across a whole band of exponents. A design that saturated at the wrong threshold would fail at exponent 158. A design that rounded ties to even, or rounded the magnitude in the wrong direction for negative inputs, would fail on the half-valued fractions.

For the integer-to-float operation, the bench walks a single set bit and several tie and near-tie patterns through every bit position, under both signs. These patterns include the significand carry that moves a result to the next exponent. A design that dropped that carry would produce an exponent one too small. The bench also checks the `done` timing cycle by cycle, so a missing or extra pipeline stage shows up as a misplaced strobe.

// File: rtl/fcvt_unit.sv
module fcvt_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] operand,
  output logic [W-1:0] result,
  output logic         done
);
  localparam int FW   = 23;
  localparam int EW   = 8;
  localparam int BIAS = 127;
  localparam int SATE = BIAS + W - 1;
  localparam int WIDE = FW + 1 + W + 1;

  logic          f_sign;
  logic [EW-1:0] f_exp;
  logic [FW-1:0] f_frac;
  assign f_sign = operand[W-1];
  assign f_exp  = operand[W-2 -: EW];
  assign f_frac = operand[FW-1:0];

  logic [WIDE-1:0] f_wide, f_shifted;
  logic [EW:0]     f_shamt;
  logic [W-1:0]    f_int, f_mag, f_conv;
  logic            f_half;

  assign f_wide    = {1'b0, 1'b1, f_frac, {W{1'b0}}};
  assign f_shamt   = (EW+1)'(BIAS + FW + W - 1) - {1'b0, f_exp};
  assign f_shifted = f_wide >> f_shamt;
  assign f_int     = f_shifted[W:1];
  assign f_half    = f_shifted[0];
  assign f_mag     = f_int + {{(W-1){1'b0}}, (op == 2'd1) & f_half};

  always_comb begin
    if (f_exp == '1 && f_frac != '0)
      f_conv = {1'b1, {(W-1){1'b0}}};
    else if (f_exp == '0)
      f_conv = '0;
    else if (int'(f_exp) >= SATE)
      f_conv = f_sign ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else
      f_conv = f_sign ? -f_mag : f_mag;
  end

  logic         s1_v, s1_sign;
  logic [W-1:0] s1_mag;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_sign <= 1'b0;
      s1_mag  <= '0;
    end else begin
      s1_v <= start && op == 2'd2;
      if (start && op == 2'd2) begin
        s1_sign <= operand[W-1];
        s1_mag  <= operand[W-1] ? -operand : operand;
      end
    end
  end

  logic [4:0] lz;
  logic       lz_found;
  always_comb begin
    lz       = '0;
    lz_found = 1'b0;
    for (int i = W-1; i >= 0; i--) begin
      if (!lz_found && s1_mag[i]) begin
        lz       = 5'(W-1-i);
        lz_found = 1'b1;
      end
    end
  end

  logic          s2_v, s2_sign, s2_zero;
  logic [W-1:0]  s2_norm;
  logic [EW-1:0] s2_exp;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v    <= 1'b0;
      s2_sign <= 1'b0;
      s2_zero <= 1'b1;
      s2_norm <= '0;
      s2_exp  <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_sign <= s1_sign;
        s2_zero <= s1_mag == '0;
        s2_norm <= s1_mag << lz;
        s2_exp  <= EW'(SATE - int'(lz));
      end
    end
  end

  logic [FW+1:0] i_mant;
  logic [EW-1:0] i_exp;
  logic [W-1:0]  i_conv;
  assign i_mant = {1'b0, s2_norm[W-1 -: FW+1]} + {{(FW+1){1'b0}}, s2_norm[W-FW-2]};
  assign i_exp  = s2_exp + {{(EW-1){1'b0}}, i_mant[FW+1]};
  assign i_conv = s2_zero ? '0 :
                  {s2_sign, i_exp, i_mant[FW+1] ? {FW{1'b0}} : i_mant[FW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= s2_v || (start && op != 2'd2);
      if (s2_v)
        result <= i_conv;
      else if (start && op != 2'd2)
        result <= (op == 2'd3) ? '0 : f_conv;
    end
  end
endmodule

// File: rtl/fcvt_unit_checker.sv
module fcvt_unit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [1:0]  op,
  input logic [31:0] operand,
  input logic [31:0] result,
  input logic        done
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_f2i_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op != 2'd2) |=> done);

  p_i2f_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 2'd2) |-> ##3 done);

  p_no_stray_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cyc == 2'd3) |-> ($past(start && op != 2'd2) || $past(start && op == 2'd2, 3)));

  p_pos_inf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !op[1] && operand == 32'h7F80_0000) |=> result == 32'h7FFF_FFFF);

  p_neg_inf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !op[1] && operand == 32'hFF80_0000) |=> result == 32'h8000_0000);

  p_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !op[1] && operand[30:23] == 8'hFF && operand[22:0] != 23'd0)
      |=> result == 32'h8000_0000);

  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !op[1] && operand[30:23] == 8'h00) |=> result == 32'h0);

  p_int_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 2'd2 && operand == 32'h0) |-> ##3 result == 32'h0);

  p_op3_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 2'd3) |=> result == 32'h0);
endmodule

bind fcvt_unit fcvt_unit_checker u_fcvt_unit_checker (.*);

// File: tb/fcvt_unit_bench.sv
module fcvt_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] operand = 32'h0;
  logic [31:0] result;
  logic        done;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fcvt_unit u_fcvt_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .operand(operand), .result(result), .done(done)
  );

  function automatic real scaled(input longint m, input int p);
    real v = m;
    if (p > 0) for (int i = 0; i < p; i++) v = v * 2.0;
    else       for (int i = 0; i < -p; i++) v = v / 2.0;
    return v;
  endfunction

  function automatic logic [31:0] ref_f2i(input logic [31:0] a, input bit rnd);
    int  e = int'(a[30:23]);
    real v;
    longint q;
    if (e == 255 && a[22:0] != 0) return 32'h8000_0000;
    if (e == 0) return 32'h0;
    if (e == 255) return a[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    v = scaled({41'd0, 1'b1, a[22:0]}, e - 150);
    if (a[31]) v = -v;
    if (v >= 2147483648.0) return 32'h7FFF_FFFF;
    if (v < -2147483648.0) return 32'h8000_0000;
    if (rnd) q = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    else     q = $rtoi(v);
    return q[31:0];
  endfunction

  function automatic logic [31:0] ref_i2f(input logic [31:0] x);
    longint mag = x[31] ? -longint'($signed(x)) : longint'(x);
    real r;
    int  sc = 0;
    longint m;
    if (mag == 0) return 32'h0;
    r = mag;
    while (r >= 16777216.0) begin r = r / 2.0; sc++; end
    while (r < 8388608.0)   begin r = r * 2.0; sc--; end
    m = $rtoi(r + 0.5);
    if (m == 64'd16777216) begin m = m / 2; sc++; end
    return {x[31], 8'(150 + sc), m[22:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [31:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    start = 1'b1; op = o; operand = a;
    @(negedge clk);
    start = 1'b0;
    if (o == 2'd2) begin
      check({tag, " R10 idle strobe"}, {31'd0, done}, 32'd0);
      @(negedge clk);
      check({tag, " R10 idle strobe"}, {31'd0, done}, 32'd0);
      @(negedge clk);
    end
    check({tag, " R8 done"}, {31'd0, done}, 32'd1);
    check(tag, result, exp);
    @(negedge clk);
    check({tag, " R10 single pulse"}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(20ns * 190000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lcg = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R10 reset done", {31'd0, done}, 32'd0);
    check("R10 reset result", result, 32'h0);
    rst_n = 1'b1;

    run(2'd0, 32'h4099_999A, 32'd4, "R1 4.8 trunc");
    run(2'd0, 32'hBFC0_0000, 32'hFFFF_FFFF, "R1 -1.5 trunc");
    run(2'd1, 32'h4099_999A, 32'd5, "R2 4.8 round");
    run(2'd1, 32'hBFC0_0000, 32'hFFFF_FFFE, "R2 -1.5 round");
    run(2'd1, 32'h4020_0000, 32'd3, "R2 2.5 round");
    run(2'd1, 32'h3F00_0000, 32'd1, "R2 0.5 round");
    run(2'd0, 32'h7F80_0000, 32'h7FFF_FFFF, "R3 +inf");
    run(2'd1, 32'h4F00_0000, 32'h7FFF_FFFF, "R3 2^31");
    run(2'd0, 32'hFF80_0000, 32'h8000_0000, "R4 -inf");
    run(2'd0, 32'hCF00_0000, 32'h8000_0000, "R4 -2^31");
    run(2'd1, 32'hCF00_0001, 32'h8000_0000, "R4 below -2^31");
    run(2'd0, 32'h7FC0_0000, 32'h8000_0000, "R5 qnan");
    run(2'd1, 32'hFF80_0001, 32'h8000_0000, "R5 snan");
    run(2'd0, 32'h807F_FFFF, 32'h0, "R6 neg subnormal");
    run(2'd1, 32'h0000_0001, 32'h0, "R6 pos subnormal");
    run(2'd3, 32'h4099_999A, 32'h0, "R9 op3");
    run(2'd2, 32'h0, 32'h0, "R7 zero");
    run(2'd2, 32'h8000_0000, 32'hCF00_0000, "R7 -2^31");
    run(2'd2, 32'h7FFF_FFFF, 32'h4F00_0000, "R7 max int");
    run(2'd2, 32'd16777217, 32'h4B80_0001, "R7 tie away");
    run(2'd2, 32'd16777219, 32'h4B80_0002, "R7 tie up");
    run(2'd2, 32'hFFFF_FFFF, 32'hBF80_0000, "R7 -1");

    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 256; e++)
        for (int k = 0; k < 6; k++) begin
          logic [22:0] fr;
          logic [31:0] a;
          case (k)
            0: fr = 23'h0;
            1: fr = 23'h1;
            2: fr = 23'h40_0000;
            3: fr = 23'h7F_FFFF;
            4: fr = 23'h3F_FFFF;
            default: begin lcg = lcg * 32'd1664525 + 32'd1013904223; fr = lcg[30:8]; end
          endcase
          a = {s[0], e[7:0], fr};
          run(2'd0, a, ref_f2i(a, 1'b0), "R1 R3 R4 R5 R6 sweep trunc");
          run(2'd1, a, ref_f2i(a, 1'b1), "R2 R3 R4 R5 R6 sweep round");
        end

    for (int b = 0; b < 32; b++)
      for (int k = 0; k < 5; k++) begin
        logic [31:0] x;
        case (k)
          0: x = 32'd1 << b;
          1: x = (32'd1 << b) | (b >= 24 ? (32'd1 << (b - 24)) : 32'd0);
          2: x = (32'd1 << b) - 32'd1;
          3: x = -(32'd1 << b);
          default: begin lcg = lcg * 32'd1664525 + 32'd1013904223; x = lcg >> (31 - b); end
        endcase
        run(2'd2, x, ref_i2f(x), "R7 sweep");
        run(2'd2, -x, ref_i2f(-x), "R7 sweep neg");
      end

    for (int i = 0; i < 1500; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      run(2'd2, lcg, ref_i2f(lcg), "R7 random");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule